// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a single-port synchronous static memory whose word is split into byte lanes (four lanes of nine bits by default). All control, address and data inputs are sampled on the rising clock edge. Each cycle is either a load cycle or an advance cycle. A load cycle starts a new access at an external address. An advance cycle continues the current burst from an internal two-bit counter. The counter starts from the low two address bits and walks the four words of the aligned group in interleaved or linear order, chosen by a static mode pin.

The memory is pipelined so that reads and writes can follow each other with no turnaround cycle. Write data is taken two enabled cycles after its address cycle. Read data appears two enabled cycles after its address cycle. A clock enable freezes the whole device, and a sleep input makes it ignore every input while keeping its contents. An asynchronous output enable gates the read bus. The bus is modelled as a drive flag plus data that reads zero while the bus is not driven.

Top module: `pipe_burst_sram`

## Requirements
- R1: On an enabled edge with `ld_n`=0 and the device selected, `addr` is captured. For a read (`we_n`=1), the stored word appears on `rdata`, with `rd_drive`=1, just after the second enabled edge that follows the one that captured the address.
- R2: For a write (`we_n`=0 at load), `wdata` is sampled at the second enabled edge after the address edge. Reads and writes can be issued on consecutive cycles in any mix with no idle cycle, and each read returns the contents left by all earlier-issued writes.
- R3: With `ord_ilv`=1, the k-th advance after a load at address A accesses the word whose upper bits match A and whose low two bits are A[1:0] XOR (k mod 4). The counter wraps after four words.
- R4: With `ord_ilv`=0, the k-th advance accesses the word whose low two bits are (A[1:0] + k) mod 4, with the upper bits unchanged.
- R5: The read/write direction is fixed at the load cycle. `we_n` has no effect on advance cycles.
- R6: The device is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. The selects are sampled only on load cycles. A deselected load performs no access, drives no read data and ends any burst, so that later advance cycles also do nothing.
- R7: `lane_we_n[i]`=0 enables writing bits [9i+8:9i]. The lane enables are sampled in the same cycle as the address, whether that cycle loads or advances. Lanes that are not enabled keep their stored value.
- R8: While `clk_en_n`=1, clock edges are ignored: no access is issued or completed, and `rdata` and `rd_drive` hold their values.
- R9: While `sleep`=1, every other synchronous input is ignored, the memory keeps its contents and all pipeline state holds.
- R10: `oe_n` acts without a clock. While it is 1, `rd_drive`=0 and `rdata`=0. While it is 0, the registered read result is shown.
- R11: After reset, `rd_drive`=0 and no burst is active, so advance cycles issued before any load perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of pipeline and burst state |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the device |
| sleep | input | 1 | 1 ignores all other inputs, keeping contents |
| ld_n | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | 0 write, 1 read; sampled on load only |
| cs0_n | input | 1 | Active-low select |
| cs1 | input | 1 | Active-high select |
| cs2_n | input | 1 | Active-low select |
| addr | input | AW | Word address |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| ord_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | LANES*LW | Write data, two enabled cycles after its address |
| rdata | output | LANES*LW | Read data, zero when not driven |
| rd_drive | output | 1 | Read bus driven flag |

## Verification
On every cycle, the embedded assertions check four things: that the burst step increments on advances, that direction is locked between loads, that a deselected load leaves the next advance idle, and that the two pipeline stages move in step and hold their outputs during a stall. The bench's scoreboard runs a reference memory and burst counter. Only those scenarios can show that data arrives at the correct address in both burst orders, including the wrap. They also show that masked lanes are preserved, that deselected, stalled and sleeping cycles leave the memory unchanged, and that the output enable gates the bus between clock edges.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

   // word offset inside the aligned group of four for step k
   function automatic logic [1:0] burst_ofs(input logic [1:0] seed,
                                             input logic [1:0] k,
                                             input logic       ilv);
      return ilv ? (seed ^ k) : (seed + k);
   endfunction
endpackage

// File: rtl/pbs_burst_ctl.sv
module pbs_burst_ctl
   import pbs_pkg::*;
#(
   parameter int AW    = 10,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ld_n,
   input  logic             we_n,
   input  logic             sel,
   input  logic             ord_ilv,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] lane_en,
   output op_e              req_op,
   output logic [AW-1:0]    req_addr,
   output logic [LANES-1:0] req_lane
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [AW-1:0] base_q;
   logic [1:0]    step_q;
   logic [1:0]    step_nx;
   logic          act_q;
   logic          dir_wr_q;

   assign step_nx = step_q + 2'd1;

   always_comb begin
      req_op   = OP_NONE;
      req_addr = addr;
      req_lane = lane_en;
      if (!ld_n) begin
         if (sel) req_op = we_n ? OP_RD : OP_WR;
      end else begin
         req_addr = {base_q[AW-1:2], burst_ofs(base_q[1:0], step_nx, ord_ilv)};
         if (act_q) req_op = dir_wr_q ? OP_WR : OP_RD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         step_q   <= '0;
         act_q    <= 1'b0;
         dir_wr_q <= 1'b0;
      end else if (en) begin
         if (!ld_n) begin
            act_q    <= sel;
            base_q   <= addr;
            step_q   <= '0;
            dir_wr_q <= ~we_n;
         end else if (act_q) begin
            step_q <= step_nx;
         end
      end
   end

   AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      en && ld_n && act_q |=> step_q == ($past(step_q) + 2'd1)); // R3

   AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      en && ld_n |=> $stable(dir_wr_q)); // R5

   AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      en && !ld_n && !sel |=> (!ld_n || req_op == OP_NONE)); // R6
endmodule

// File: rtl/pbs_pipe.sv
module pbs_pipe
   import pbs_pkg::*;
#(
   parameter int AW    = 10,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  op_e              in_op,
   input  logic [AW-1:0]    in_addr,
   input  logic [LANES-1:0] in_lane,
   output op_e              out_op,
   output logic [AW-1:0]    out_addr,
   output logic [LANES-1:0] out_lane
);
   timeunit 1ns;
   timeprecision 1ps;

   op_e              s1_op;
   logic [AW-1:0]    s1_addr;
   logic [LANES-1:0] s1_lane;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op    <= OP_NONE;
         s1_addr  <= '0;
         s1_lane  <= '0;
         out_op   <= OP_NONE;
         out_addr <= '0;
         out_lane <= '0;
      end else if (en) begin
         s1_op    <= in_op;
         s1_addr  <= in_addr;
         s1_lane  <= in_lane;
         out_op   <= s1_op;
         out_addr <= s1_addr;
         out_lane <= s1_lane;
      end
   end

   AST_STAGE_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> out_op == $past(s1_op)); // R1
endmodule

// File: rtl/pbs_store.sv
module pbs_store
   import pbs_pkg::*;
#(
   parameter int AW    = 10,
   parameter int LANES = 4,
   parameter int LW    = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  op_e                 op,
   input  logic [AW-1:0]       addr,
   input  logic [LANES-1:0]    lane,
   input  logic [LANES*LW-1:0] wdata,
   output logic [LANES*LW-1:0] rd_q,
   output logic                rd_vld_q
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DEPTH = 1 << AW;
   localparam int DW    = LANES * LW;

   logic [DW-1:0] rd_word;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (en && op == OP_WR && lane[g]) mem[addr] <= wdata[g*LW +: LW];
      end
      assign rd_word[g*LW +: LW] = mem[addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q     <= '0;
         rd_vld_q <= 1'b0;
      end else if (en) begin
         rd_vld_q <= (op == OP_RD);
         if (op == OP_RD) rd_q <= rd_word;
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(rd_vld_q) && $stable(rd_q)); // R8
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
   import pbs_pkg::*;
#(
   parameter int AW    = 10,
   parameter int LANES = 4,
   parameter int LW    = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clk_en_n,
   input  logic                sleep,
   input  logic                ld_n,
   input  logic                we_n,
   input  logic                cs0_n,
   input  logic                cs1,
   input  logic                cs2_n,
   input  logic [AW-1:0]       addr,
   input  logic [LANES-1:0]    lane_we_n,
   input  logic                ord_ilv,
   input  logic                oe_n,
   input  logic [LANES*LW-1:0] wdata,
   output logic [LANES*LW-1:0] rdata,
   output logic                rd_drive
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DW = LANES * LW;

   if (AW < 3 || AW > 20) begin : g_bad_aw
      $error("pipe_burst_sram: AW must be in 3..20");
   end
   if (LANES < 1 || LW < 1) begin : g_bad_lane
      $error("pipe_burst_sram: LANES and LW must be positive");
   end

   logic             en;
   logic             sel;
   op_e              c_op, p_op;
   logic [AW-1:0]    c_addr, p_addr;
   logic [LANES-1:0] c_lane, p_lane;
   logic [DW-1:0]    rd_q;
   logic             rd_vld_q;

   assign en  = ~clk_en_n & ~sleep;
   assign sel = ~cs0_n & cs1 & ~cs2_n;

   pbs_burst_ctl #(.AW(AW), .LANES(LANES)) u_ctl (
      .clk(clk), .rst_n(rst_n), .en(en), .ld_n(ld_n), .we_n(we_n), .sel(sel),
      .ord_ilv(ord_ilv), .addr(addr), .lane_en(~lane_we_n),
      .req_op(c_op), .req_addr(c_addr), .req_lane(c_lane));

   pbs_pipe #(.AW(AW), .LANES(LANES)) u_pipe (
      .clk(clk), .rst_n(rst_n), .en(en),
      .in_op(c_op), .in_addr(c_addr), .in_lane(c_lane),
      .out_op(p_op), .out_addr(p_addr), .out_lane(p_lane));

   pbs_store #(.AW(AW), .LANES(LANES), .LW(LW)) u_store (
      .clk(clk), .rst_n(rst_n), .en(en), .op(p_op), .addr(p_addr),
      .lane(p_lane), .wdata(wdata), .rd_q(rd_q), .rd_vld_q(rd_vld_q));

   assign rd_drive = rd_vld_q & ~oe_n;
   assign rdata    = rd_drive ? rd_q : '0;
endmodule

// File: tb/pipe_burst_sram_tb_top.sv
module pipe_burst_sram_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [2:0] SEL = 3'b010;   // {cs2_n, cs1, cs0_n}

   logic        clk = 0, rst_n = 0;
   logic        clk_en_n = 0, sleep = 0, ld_n = 1, we_n = 1;
   logic        cs0_n = 1, cs1 = 0, cs2_n = 1, ord_ilv = 1, oe_n = 0;
   logic [9:0]  addr = '0;
   logic [3:0]  lane_we_n = '1;
   logic [35:0] wdata = '0;
   logic [35:0] rdata;
   logic        rd_drive;

   pipe_burst_sram dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep), .ld_n(ld_n),
      .we_n(we_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .addr(addr),
      .lane_we_n(lane_we_n), .ord_ilv(ord_ilv), .oe_n(oe_n), .wdata(wdata),
      .rdata(rdata), .rd_drive(rd_drive));

   always #5 clk = ~clk;

   typedef struct { bit v; logic [35:0] d; string t; } exp_t;
   exp_t expq[$];
   exp_t last_e;

   int total = 0, bad = 0;
   bit done = 0;
   string cur = "R11";

   logic [35:0] refm [int];
   bit          bq_v [2];
   bit          bq_w [2];
   int          bq_a [2];
   logic [35:0] bq_d [2];
   logic [3:0]  bq_l [2];
   string       bq_t [2];
   int m_base = 0, m_step = 0;
   bit m_act = 0, m_dir = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [35:0] act, input logic [35:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [35:0] rnd36();
      return {4'($urandom), 32'($urandom)};
   endfunction

   // driver: one call per clock; pushes the expected result of this edge
   task automatic cyc(input bit ld, input bit wr, input int a, input logic [2:0] cs,
                      input logic [3:0] lwn, input bit stall = 0, input bit slp = 0);
      exp_t e;
      int na;
      bit nv, nw;
      @(negedge clk);
      ld_n = ld; we_n = ~wr; addr = 10'(a);
      {cs2_n, cs1, cs0_n} = cs;
      lane_we_n = lwn; clk_en_n = stall; sleep = slp;
      wdata = rnd36();
      if (stall || slp) begin
         e = last_e; e.t = cur;
         expq.push_back(e);
         return;
      end
      e.v = 0; e.d = '0; e.t = bq_t[1];
      if (bq_v[1] && bq_w[1]) begin
         wdata = bq_d[1];
         for (int i = 0; i < 4; i++)
            if (bq_l[1][i]) refm[bq_a[1]][i*9 +: 9] = bq_d[1][i*9 +: 9];
      end else if (bq_v[1]) begin
         e.v = 1; e.d = refm[bq_a[1]];
      end
      expq.push_back(e);
      last_e = e;
      nv = 0; nw = 0; na = a;
      if (!ld) begin
         m_act = (cs == SEL); m_base = a; m_step = 0; m_dir = wr;
         nv = m_act; nw = wr;
      end else if (m_act) begin
         m_step = (m_step + 1) % 4;
         na = (m_base & ~3) | (ord_ilv ? ((m_base & 3) ^ m_step)
                                       : (((m_base & 3) + m_step) % 4));
         nv = 1; nw = m_dir;
      end
      bq_v[1] = bq_v[0]; bq_w[1] = bq_w[0]; bq_a[1] = bq_a[0];
      bq_d[1] = bq_d[0]; bq_l[1] = bq_l[0]; bq_t[1] = bq_t[0];
      bq_v[0] = nv; bq_w[0] = nw; bq_a[0] = na;
      bq_d[0] = rnd36(); bq_l[0] = ~lwn; bq_t[0] = cur;
   endtask

   task automatic nop();
      cyc(0, 0, 0, 3'b011, 4'hf);
   endtask

   // monitor: compares after every edge once the driver is running
   initial begin
      exp_t e;
      forever begin
         @(posedge clk); #1;
         if (expq.size() > 0) begin
            e = expq.pop_front();
            if (e.v) begin
               chk(rd_drive === 1'b1, e.t, "rd_drive", 36'(rd_drive), 36'd1);
               chk(rdata === e.d, e.t, "rdata", rdata, e.d);
            end else begin
               chk(rd_drive === 1'b0, e.t, "rd_drive idle", 36'(rd_drive), 36'd0);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      last_e.v = 0; last_e.d = '0; last_e.t = "";
      for (int i = 0; i < 2; i++) begin
         bq_v[i] = 0; bq_w[i] = 0; bq_a[i] = 0; bq_d[i] = '0; bq_l[i] = '0; bq_t[i] = "";
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      chk(rd_drive === 1'b0, "R11", "reset rd_drive", 36'(rd_drive), 36'd0);
      // R11: advance with no burst loaded does nothing
      cur = "R11"; cyc(1, 1, 5, SEL, 4'h0); cyc(1, 0, 6, SEL, 4'h0); nop(); nop();
      // R2: back-to-back full writes, then R1 reads
      cur = "R2"; for (int k = 0; k < 8; k++) cyc(0, 1, 16 + k, SEL, 4'h0);
      cur = "R1"; for (int k = 0; k < 8; k++) cyc(0, 0, 16 + k, SEL, 4'h0);
      cur = "R2";
      cyc(0, 1, 20, SEL, 4'h0); cyc(0, 0, 16, SEL, 4'h0); cyc(0, 1, 21, SEL, 4'h0);
      cyc(0, 0, 20, SEL, 4'h0); cyc(0, 0, 21, SEL, 4'h0); nop(); nop();
      // R3: interleaved write burst from 0x41, read burst from 0x42 with wrap
      cur = "R3"; ord_ilv = 1;
      cyc(0, 1, 'h41, SEL, 4'h0); for (int k = 0; k < 3; k++) cyc(1, 1, 0, SEL, 4'h0);
      cyc(0, 0, 'h42, SEL, 4'h0); for (int k = 0; k < 4; k++) cyc(1, 0, 0, SEL, 4'h0);
      nop(); nop();
      // R4: linear write burst from 0x83, read bursts from 0x81 and 0x40
      cur = "R4"; ord_ilv = 0;
      cyc(0, 1, 'h83, SEL, 4'h0); for (int k = 0; k < 3; k++) cyc(1, 1, 0, SEL, 4'h0);
      cyc(0, 0, 'h81, SEL, 4'h0); for (int k = 0; k < 4; k++) cyc(1, 0, 0, SEL, 4'h0);
      cyc(0, 0, 'h40, SEL, 4'h0); for (int k = 0; k < 3; k++) cyc(1, 0, 0, SEL, 4'h0);
      nop(); nop();
      // R5: write strobe on advance cycles changes nothing
      cur = "R5";
      cyc(0, 0, 16, SEL, 4'h0); for (int k = 0; k < 3; k++) cyc(1, 1, 0, SEL, 4'h0);
      cyc(0, 1, 'h80, SEL, 4'h0); for (int k = 0; k < 3; k++) cyc(1, 0, 0, SEL, 4'h0);
      cyc(0, 0, 16, SEL, 4'h0); for (int k = 0; k < 3; k++) cyc(1, 0, 0, SEL, 4'h0);
      cyc(0, 0, 'h80, SEL, 4'h0); for (int k = 0; k < 3; k++) cyc(1, 0, 0, SEL, 4'h0);
      nop(); nop();
      // R6: each deselect pattern blocks the write; advances after it are idle
      cur = "R6";
      cyc(0, 1, 16, 3'b011, 4'h0); cyc(0, 1, 16, 3'b000, 4'h0); cyc(0, 1, 16, 3'b110, 4'h0);
      cyc(1, 1, 0, SEL, 4'h0); cyc(1, 0, 0, SEL, 4'h0);
      cyc(0, 0, 16, SEL, 4'h0);
      cyc(0, 0, 'h40, SEL, 4'h0); cyc(1, 0, 0, 3'b111, 4'h0); cyc(1, 0, 0, 3'b101, 4'h0);
      nop(); nop();
      // R7: lane masks on a single write and on each step of a burst
      cur = "R7";
      cyc(0, 1, 17, SEL, 4'b1010); cyc(0, 0, 17, SEL, 4'h0);
      cyc(0, 1, 'h80, SEL, 4'b0111); cyc(1, 1, 0, SEL, 4'b1110);
      cyc(1, 1, 0, SEL, 4'b0000); cyc(1, 1, 0, SEL, 4'b1111);
      cyc(0, 0, 'h80, SEL, 4'h0); for (int k = 0; k < 3; k++) cyc(1, 0, 0, SEL, 4'h0);
      nop(); nop();
      // R8: stalls inside read and write pipelines, ignored load during stall
      cur = "R8";
      cyc(0, 0, 'h41, SEL, 4'h0); nop();
      cyc(0, 1, 'h43, SEL, 4'h0, 1); cyc(0, 1, 'h43, SEL, 4'h0, 1);
      cyc(0, 1, 'h42, SEL, 4'h0); cyc(0, 0, 'h41, SEL, 4'h0, 1);
      nop(); cyc(1, 1, 0, SEL, 4'h0, 1); nop(); nop();
      cyc(0, 0, 'h42, SEL, 4'h0); cyc(0, 0, 'h43, SEL, 4'h0); nop(); nop();
      // R9: sleep ignores loads and freezes the pipeline
      cur = "R9";
      cyc(0, 0, 'h83, SEL, 4'h0); cyc(0, 1, 'h83, SEL, 4'h0, 0, 1);
      cyc(0, 1, 'h82, SEL, 4'h0, 0, 1); nop(); cyc(1, 1, 0, SEL, 4'h0, 0, 1); nop();
      cyc(0, 0, 'h83, SEL, 4'h0); cyc(0, 0, 'h82, SEL, 4'h0); nop(); nop();
      // R10: output enable gates the bus between edges
      cur = "R10";
      cyc(0, 0, 22, SEL, 4'h0); nop(); nop();
      cyc(0, 0, 0, SEL, 4'h0, 1);
      @(posedge clk); #2;
      oe_n = 1; #1;
      chk(rd_drive === 1'b0, "R10", "oe off drive", 36'(rd_drive), 36'd0);
      chk(rdata === 36'd0, "R10", "oe off data", rdata, 36'd0);
      oe_n = 0; #1;
      chk(rd_drive === 1'b1, "R10", "oe on drive", 36'(rd_drive), 36'd1);
      chk(rdata === refm[22], "R10", "oe on data", rdata, refm[22]);
      nop(); nop(); nop();
      while (expq.size() > 0) @(posedge clk);
      @(posedge clk); #2;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule